// File: doc/BRIEF.md
# UART Receive Status Capture

This block sits behind a UART receiver's deserializer. Each received character arrives as a one-cycle strobe with eight data bits and three line-error flags: framing, parity and break. The block stores the character with its flags as one 12-bit entry. With the FIFO switched on, storage is a FIFO of `DEPTH` entries. With it switched off, storage is a single holding register. A read strobe on the data location returns the oldest entry on a registered read port.

A separate 4-bit status register tracks errors. Its framing, parity and break bits are loaded only when a data read returns an entry, so they always describe the character most recently read. Its overrun bit is set the moment a character is lost because storage was full. A write strobe on the error-clear location wipes all four status bits.

The block also drives empty and full flags for the active storage mode. It drives an active-low request-to-send output, which with flow control enabled withdraws the request while storage is full.

Top module: `rx_status_capture`

## Requirements
- R1: Each stored entry holds data in bits 7:0, framing error in bit 8, parity error in bit 9, break in bit 10 and overrun in bit 11. Data reads return entries in arrival order.
- R2: `rd_data` takes the returned entry on the clock edge that samples `data_rd`. It is visible in the following cycle and is held until the next successful read.
- R3: `rx_status` bit 0 is framing, bit 1 is parity, bit 2 is break and bit 3 is overrun. Bits 2:0 are loaded from bits 10:8 of the entry returned by a data read, and change at no other time except through R5.
- R4: A character that arrives while storage is full is dropped. `rx_status` bit 3 is set on that same edge without any read, and bit 11 of the next character stored is 1.
- R5: A pulse on `err_clr` clears all four `rx_status` bits.
- R6: With `fifo_en` = 0, storage holds one character. The first character makes the block full, and a second one before a read is an overrun (R4).
- R7: `rx_empty` is 1 when nothing is stored. `rx_full` is 1 when the stored count equals the capacity: `DEPTH` with `fifo_en` = 1, and 1 otherwise.
- R8: After reset, `rx_status` is 0, `rd_data` is 0, `rx_empty` is 1 and `rx_full` is 0.
- R9: A data read while storage is empty leaves `rd_data` unchanged and moves no pointer. The next character stored is the next one returned.
- R10: With `rts_flow_en` = 1, `rts_n` is 0 while there is room for another character and 1 while storage is full. With `rts_flow_en` = 0, `rts_n` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe: a received character is presented |
| char_data | input | 8 | Received data bits |
| char_frm | input | 1 | Framing error of the presented character |
| char_par | input | 1 | Parity error of the presented character |
| char_brk | input | 1 | Break condition on the presented character |
| fifo_en | input | 1 | 1 = FIFO storage, 0 = single holding register |
| rts_flow_en | input | 1 | Enables hardware request-to-send flow control |
| data_rd | input | 1 | Read strobe for the data location |
| err_clr | input | 1 | Write strobe for the error-clear location |
| rd_data | output | 12 | Last entry returned by a data read |
| rx_status | output | 4 | Receive status register |
| rx_empty | output | 1 | Storage empty |
| rx_full | output | 1 | Storage full |
| rts_n | output | 1 | Active-low request to send |

## Verification
The bench builds the block with the default `DEPTH` of 16. This selects the power-of-two pointer variant, in which the pointers wrap on their own.

That depth is small enough to fill storage completely and push one extra character. So the overrun path, the tagging of the next stored character, and request-to-send deassertion at full are all exercised in FIFO mode. The same sequence is then repeated at a capacity of one in holding-register mode. The explicit-wrap pointer variant for other depths is not reached with this parameter value.

// File: rtl/rxsc_pkg.sv
package rxsc_pkg;
   localparam int DATA_W = 8;

   // Field order is behaviour: software decodes these bit positions.
   typedef struct packed {
      logic              ovr;   // bit 11
      logic              brk;   // bit 10
      logic              par;   // bit 9
      logic              frm;   // bit 8
      logic [DATA_W-1:0] data;  // bits 7:0
   } rx_entry_t;

   localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/rxsc_store.sv
module rxsc_store
   import rxsc_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              push_req,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_frm,
   input  logic              push_par,
   input  logic              push_brk,
   input  logic              pop_req,
   output rx_entry_t         rd_q,
   output logic [2:0]        head_flags,
   output logic              empty,
   output logic              full,
   output logic              overrun,
   output logic              pop_ok
);
   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CNT_W = $clog2(DEPTH + 1);
   localparam bit  POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxsc_store: DEPTH must be at least 2");
      end
   endgenerate

   rx_entry_t        mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count, cap;
   logic             push_ok, ovr_pend;

   assign cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
   assign empty   = (count == '0);
   assign full    = (count >= cap);
   assign push_ok = push_req && !full;
   assign overrun = push_req && full;
   assign pop_ok  = pop_req && !empty;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign head_flags = {mem[rd_ptr].brk, mem[rd_ptr].par, mem[rd_ptr].frm};

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_ptr] <= '{ovr: ovr_pend, brk: push_brk, par: push_par,
                          frm: push_frm, data: push_data};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         ovr_pend <= 1'b0;
         rd_q     <= '0;
      end else begin
         if (push_ok) begin
            wr_ptr   <= wr_nxt;
            ovr_pend <= 1'b0;
         end else if (overrun) begin
            ovr_pend <= 1'b1;
         end
         if (pop_ok) begin
            rd_ptr <= rd_nxt;
            rd_q   <= mem[rd_ptr];
         end
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R7: the stored count never exceeds the physical depth
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   // R4: a dropped character leaves the occupancy unchanged
   a_r4_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !pop_ok) |=> $stable(count));
   // R9: a read of empty storage holds the read port
   a_r9_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && empty && !push_req) |=> ($stable(rd_q) && empty));
   // R6: holding-register mode keeps at most one character
   a_r6_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && $past(!fifo_en) && ($past(count) <= 1)) |-> (count <= 1));
endmodule

// File: rtl/rxsc_status.sv
module rxsc_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pop_ok,
   input  logic [2:0] head_flags,
   input  logic       overrun,
   input  logic       clr,
   output logic [3:0] status
);
   // Clear is applied first; a read or overrun on the same edge wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
      end else begin
         if (clr)     status      <= '0;
         if (pop_ok)  status[2:0] <= head_flags;
         if (overrun) status[3]   <= 1'b1;
      end
   end

   // R4: overrun shows up without waiting for a read
   a_r4_overrun_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> status[3]);
   // R5: a clear with no competing event leaves all bits low
   a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !overrun && !pop_ok) |=> (status == 4'b0000));
   // R3: line-error bits move only on a data read or a clear
   a_r3_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop_ok && !clr) |=> $stable(status[2:0]));
endmodule

// File: rtl/rx_status_capture.sv
module rx_status_capture
   import rxsc_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               char_valid,
   input  logic [DATA_W-1:0]  char_data,
   input  logic               char_frm,
   input  logic               char_par,
   input  logic               char_brk,
   input  logic               fifo_en,
   input  logic               rts_flow_en,
   input  logic               data_rd,
   input  logic               err_clr,
   output logic [ENTRY_W-1:0] rd_data,
   output logic [3:0]         rx_status,
   output logic               rx_empty,
   output logic               rx_full,
   output logic               rts_n
);
   rx_entry_t  rd_q;
   logic [2:0] head_flags;
   logic       overrun, pop_ok;

   rxsc_store #(.DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_en    (fifo_en),
      .push_req   (char_valid),
      .push_data  (char_data),
      .push_frm   (char_frm),
      .push_par   (char_par),
      .push_brk   (char_brk),
      .pop_req    (data_rd),
      .rd_q       (rd_q),
      .head_flags (head_flags),
      .empty      (rx_empty),
      .full       (rx_full),
      .overrun    (overrun),
      .pop_ok     (pop_ok)
   );

   rxsc_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .pop_ok     (pop_ok),
      .head_flags (head_flags),
      .overrun    (overrun),
      .clr        (err_clr),
      .status     (rx_status)
   );

   assign rd_data = rd_q;
   assign rts_n   = rts_flow_en & rx_full;

   // R10: request stays asserted (low) while there is room
   a_r10_rts_room: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_full |-> !rts_n);
endmodule

// File: tb/sim_rx_status_capture.sv
module sim_rx_status_capture;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        char_valid = 1'b0, char_frm = 1'b0, char_par = 1'b0, char_brk = 1'b0;
   logic [7:0]  char_data = '0;
   logic        fifo_en = 1'b1, rts_flow_en = 1'b1, data_rd = 1'b0, err_clr = 1'b0;
   logic [11:0] rd_data;
   logic [3:0]  rx_status;
   logic        rx_empty, rx_full, rts_n;

   always #10 clk = ~clk;  // 50 MHz

   rx_status_capture #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
      .char_frm(char_frm), .char_par(char_par), .char_brk(char_brk),
      .fifo_en(fifo_en), .rts_flow_en(rts_flow_en), .data_rd(data_rd),
      .err_clr(err_clr), .rd_data(rd_data), .rx_status(rx_status),
      .rx_empty(rx_empty), .rx_full(rx_full), .rts_n(rts_n));

   int          n_vec = 0, n_bad = 0;
   bit          done = 1'b0;
   logic [11:0] exp_q[$];
   logic        ovr_pend = 1'b0, ovr_stat = 1'b0;
   logic [2:0]  fpb = '0;
   logic [11:0] last_rd = '0;
   logic        rd_arm = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver: presents one character and records what storage should hold.
   task automatic send(input logic [7:0] d, input logic f, input logic p, input logic b);
      int cap;
      cap = fifo_en ? DEPTH : 1;
      @(negedge clk);
      char_valid = 1'b1; char_data = d; char_frm = f; char_par = p; char_brk = b;
      if (exp_q.size() < cap) begin
         exp_q.push_back({ovr_pend, b, p, f, d});
         ovr_pend = 1'b0;
      end else begin
         ovr_pend = 1'b1;
         ovr_stat = 1'b1;
      end
      @(negedge clk);
      char_valid = 1'b0;
      #1;
   endtask

   task automatic rd_one();
      @(negedge clk);
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
      #1;
   endtask

   task automatic clear_err();
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      ovr_stat = 1'b0;
      fpb = '0;
      #1;
      check(rx_status == 4'b0000, "R5 status after clear", rx_status, 0);
   endtask

   task automatic chk_flags(input string req);
      int  cap;
      bit  e_full;
      cap = fifo_en ? DEPTH : 1;
      e_full = (exp_q.size() >= cap);
      check(rx_empty == (exp_q.size() == 0), {req, " empty flag"}, rx_empty, exp_q.size() == 0);
      check(rx_full == e_full, {req, " full flag"}, rx_full, e_full);
      check(rts_n == (rts_flow_en && e_full), {req, " rts_n"}, rts_n, rts_flow_en && e_full);
      check(rx_status == {ovr_stat, fpb}, {req, " status"}, rx_status, {ovr_stat, fpb});
   endtask

   // Monitor: every read is compared with the scoreboard head.
   always @(posedge clk) rd_arm <= data_rd;

   always @(negedge clk) begin : mon
      logic [11:0] e;
      if (rd_arm) begin
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            fpb = e[10:8];
            last_rd = e;
            check(rd_data == e, "R1 R2 read entry", rd_data, e);
         end else begin
            e = last_rd;
            check(rd_data == e, "R9 empty read holds", rd_data, e);
         end
         check(rx_status == {ovr_stat, fpb}, "R3 status after read", rx_status, {ovr_stat, fpb});
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8: reset state
      check(rd_data == 12'h000, "R8 rd_data", rd_data, 0);
      check(rx_status == 4'h0, "R8 status", rx_status, 0);
      check(rx_empty == 1'b1, "R8 empty", rx_empty, 1);
      check(rx_full == 1'b0, "R8 full", rx_full, 0);
      check(rts_n == 1'b0, "R10 rts after reset", rts_n, 0);

      // R3: arrival alone leaves status untouched
      send(8'hA5, 1'b1, 1'b0, 1'b0);
      check(rx_status == 4'h0, "R3 no update on arrival", rx_status, 0);
      chk_flags("R7 one stored");
      send(8'h3C, 1'b0, 1'b1, 1'b0);
      send(8'h00, 1'b0, 1'b0, 1'b1);
      send(8'h7E, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 4; i++) rd_one();
      chk_flags("R7 drained");

      // R9: empty read, then pointers still line up
      rd_one();
      send(8'h55, 1'b0, 1'b0, 1'b0);
      rd_one();

      // R4, R7, R10: fill, overflow, drain
      for (int i = 0; i < DEPTH; i++) send(8'(i * 7 + 1), i[0], i[1], i[2]);
      chk_flags("R7 R10 full FIFO");
      send(8'hFF, 1'b0, 1'b0, 1'b1);
      check(rx_status[3] == 1'b1, "R4 overrun immediate", rx_status[3], 1);
      chk_flags("R4 after drop");
      for (int i = 0; i < DEPTH; i++) rd_one();
      send(8'h11, 1'b0, 1'b0, 1'b0);
      rd_one();  // entry carries bit 11
      clear_err();

      // R6: holding-register mode
      fifo_en = 1'b0;
      send(8'h21, 1'b0, 1'b1, 1'b0);
      chk_flags("R6 one entry full");
      send(8'h22, 1'b1, 1'b0, 1'b0);
      check(rx_status[3] == 1'b1, "R6 second char overruns", rx_status[3], 1);
      rd_one();
      send(8'h33, 1'b0, 1'b0, 1'b0);
      rd_one();
      clear_err();

      // R10: flow control off keeps request asserted at full
      rts_flow_en = 1'b0;
      send(8'h44, 1'b0, 1'b0, 1'b0);
      chk_flags("R10 flow off");
      rd_one();
      chk_flags("R7 final");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule